// File: doc/BRIEF.md
# Switchable Boot ROM Window Controller

This block decides whether a small resident boot ROM answers memory reads. It watches a 16-bit memory address bus and the memory read and write strobes. It asserts the ROM chip-enable only for reads that fall in a fixed 1 KB window, 0xC000 to 0xC3FF. A mapping flag inside the block is set by reset. An operating system can clear it once bootstrap is done by writing to I/O port 0x40, which frees the window for RAM. It clears only if the matching configuration switch allows it.

Four static configuration switches are sampled through a synchronizer. The first removes the ROM from the map completely. The second allows the port write to unmap the ROM. The third is reported as a status bit that tells the firmware to bootstrap straight away instead of starting in the console monitor. The fourth locks out diskette formatting: while it is on, the format request strobe bound for the disk controller is held off. All pins are plain level controls. There is no streamed data and no handshake.

Top module: `boot_rom_window`

## Requirements
- R1: With the mapping flag set and the ROM-off switch off, `rom_ce` is 1 in the same cycle as a read (`mem_rd`=1, `mem_wr`=0) whose address lies in 0xC000..0xC3FF inclusive, and 0 for 0xBFFF, 0xC400 and every other address.
- R2: While the ROM-off switch (`sw_rom_off`=1) is on, `rom_ce` stays 0 for every address and strobe pattern.
- R3: `rom_ce` is 0 whenever `mem_wr`=1 or `mem_rd`=0, including addresses inside the window.
- R4: With the auto-off switch on, an I/O write (`io_wr`=1) with `io_addr`=0x40 clears the mapping flag at that clock edge. From the next cycle on, window reads give `rom_ce`=0.
- R5: With the auto-off switch off, an I/O write to port 0x40 leaves the mapping flag set, and window reads still give `rom_ce`=1.
- R6: I/O writes to any port other than 0x40 never change the mapping flag.
- R7: Reset (`rst_n`=0, asynchronous) sets the mapping flag, so the ROM is mapped again after every reset.
- R8: Once cleared, the mapping flag stays cleared until the next reset, even if the auto-off switch is later turned off.
- R9: `boot_direct` follows `sw_boot_direct` and `fmt_locked` follows `sw_fmt_lock`. Both lag by the synchronizer depth (2 clock edges by default) and are 0 during reset.
- R10: `fmt_grant` equals `fmt_req` while `fmt_locked` is 0, and is 0 while `fmt_locked` is 1.
- R11: Every switch reaches the decode only after the synchronizer depth. A switch change is seen by `rom_ce` no sooner than 2 clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; sets the mapping flag |
| mem_addr | input | 16 | Memory address bus |
| mem_rd | input | 1 | Memory read cycle in progress |
| mem_wr | input | 1 | Memory write cycle in progress |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | I/O write strobe, sampled on the clock edge |
| sw_rom_off | input | 1 | Switch: ROM removed from the map when 1 |
| sw_auto_off | input | 1 | Switch: port 0x40 write may unmap the ROM when 1 |
| sw_boot_direct | input | 1 | Switch: firmware bootstraps without the monitor when 1 |
| sw_fmt_lock | input | 1 | Switch: diskette formatting blocked when 1 |
| fmt_req | input | 1 | Format command request from the host side |
| rom_ce | output | 1 | ROM chip-enable |
| boot_direct | output | 1 | Synchronized boot-mode status bit |
| fmt_locked | output | 1 | Synchronized format-protect flag |
| fmt_grant | output | 1 | Format request passed on to the disk controller |

## Verification
A mapping flag that clears wrongly, or fails to clear, is seen on the first window read after the port write. `rom_ce` then differs at 0xC000 or 0xC3FF in the very next cycle. A flag that comes back without reset is exposed later, when the bench turns the auto-off switch off again and reads the window. A decoder off by one address shows up at once as a wrong `rom_ce` at 0xBFFF or 0xC400. A wrong synchronizer depth shows up as status bits or a decode that change a cycle too early or too late after a switch flip.

// File: rtl/boot_win_pkg.sv
package boot_win_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned PORT_W   = 8;
  localparam int unsigned SYNC_LEN = 2;

  typedef struct packed {
    logic rom_off;
    logic auto_off;
    logic boot_direct;
    logic fmt_lock;
  } cfg_sw_t;

  localparam int unsigned CFG_W = $bits(cfg_sw_t);
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

  // R11
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (STAGES == 2) && $past(rst_n) |-> q == $past(stage_q[0]));
endmodule

// File: rtl/win_decode.sv
module win_decode #(
  parameter int unsigned AW   = 16,
  parameter logic [AW-1:0] BASE = 16'hC000,
  parameter int unsigned SIZE = 1024
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW:0] LO = {1'b0, BASE};
  localparam logic [AW:0] HI = LO + (AW+1)'(SIZE);

  logic [AW:0] a_ext;
  assign a_ext = {1'b0, addr};
  assign hit   = (a_ext >= LO) && (a_ext < HI);
endmodule

// File: rtl/map_latch.sv
module map_latch #(
  parameter int unsigned PW = 8,
  parameter logic [PW-1:0] PORT = 8'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic [PW-1:0] io_addr,
  input  logic          allow_clear,
  output logic          mapped
);
  logic clear_hit;
  assign clear_hit = io_wr && (io_addr == PORT) && allow_clear;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         mapped <= 1'b1;
    else if (clear_hit) mapped <= 1'b0;

  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && io_addr == PORT && allow_clear |=> !mapped);
  // R6
  other_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr || io_addr != PORT) && mapped |=> mapped);
  // R8
  no_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(mapped));
endmodule

// File: rtl/boot_rom_window.sv
module boot_rom_window
  import boot_win_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hC000,
  parameter int unsigned       ROM_SIZE = 1024,
  parameter logic [PORT_W-1:0] OFF_PORT = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [PORT_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              sw_rom_off,
  input  logic              sw_auto_off,
  input  logic              sw_boot_direct,
  input  logic              sw_fmt_lock,
  input  logic              fmt_req,
  output logic              rom_ce,
  output logic              boot_direct,
  output logic              fmt_locked,
  output logic              fmt_grant
);
  cfg_sw_t sw_raw, sw_s;
  logic    win_hit, mapped;

  assign sw_raw = '{rom_off: sw_rom_off, auto_off: sw_auto_off,
                    boot_direct: sw_boot_direct, fmt_lock: sw_fmt_lock};

  cfg_sync #(.W(CFG_W), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sw_raw), .q(sw_s)
  );

  win_decode #(.AW(ADDR_W), .BASE(ROM_BASE), .SIZE(ROM_SIZE)) u_dec (
    .addr(mem_addr), .hit(win_hit)
  );

  map_latch #(.PW(PORT_W), .PORT(OFF_PORT)) u_map (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .allow_clear(sw_s.auto_off), .mapped(mapped)
  );

  assign rom_ce      = win_hit && mapped && !sw_s.rom_off && mem_rd && !mem_wr;
  assign boot_direct = sw_s.boot_direct;
  assign fmt_locked  = sw_s.fmt_lock;
  assign fmt_grant   = fmt_req && !sw_s.fmt_lock;

  // R2
  rom_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_s.rom_off |-> !rom_ce);
  // R3
  write_no_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || !mem_rd) |-> !rom_ce);
  // R1
  outside_no_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> !rom_ce);
  // R10
  fmt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_locked |-> !fmt_grant);
endmodule

// File: tb/sim_boot_rom_window.sv
module sim_boot_rom_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0;
  logic [7:0]  io_addr = '0;
  logic        io_wr = 1'b0;
  logic        s_off = 1'b0, s_auto = 1'b0, s_boot = 1'b0, s_fmt = 1'b0;
  logic        fmt_req = 1'b0;
  logic        rom_ce, boot_direct, fmt_locked, fmt_grant;

  int checks = 0;
  int errors = 0;
  logic exp_mapped;
  logic done = 1'b0;

  always #5 clk = ~clk;

  boot_rom_window u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_addr(io_addr), .io_wr(io_wr),
    .sw_rom_off(s_off), .sw_auto_off(s_auto), .sw_boot_direct(s_boot),
    .sw_fmt_lock(s_fmt), .fmt_req(fmt_req), .rom_ce(rom_ce),
    .boot_direct(boot_direct), .fmt_locked(fmt_locked), .fmt_grant(fmt_grant)
  );

  function automatic logic exp_ce(logic [15:0] a, logic rd, logic wr,
                                  logic mp, logic off);
    return (a >= 16'hC000) && (a <= 16'hC3FF) && rd && !wr && mp && !off;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual %0b expected %0b", tag, mem_addr, act, exp);
    end
  endtask

  task automatic rd_probe(string tag, logic [15:0] a, logic rd, logic wr);
    @(negedge clk);
    mem_addr = a; mem_rd = rd; mem_wr = wr;
    #2 chk(tag, rom_ce, exp_ce(a, rd, wr, exp_mapped, s_off));
  endtask

  task automatic io_write(logic [7:0] p);
    @(negedge clk);
    io_addr = p; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (p == 8'h40 && s_auto) exp_mapped = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic sweep(string tag);
    logic [15:0] pts [4] = '{16'hBFFF, 16'hC000, 16'hC3FF, 16'hC400};
    foreach (pts[i]) begin
      rd_probe(tag, pts[i], 1'b1, 1'b0);
      rd_probe({tag, " R3 wr"}, pts[i], 1'b0, 1'b1);
      rd_probe({tag, " R3 rdwr"}, pts[i], 1'b1, 1'b1);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    exp_mapped = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset values
    chk("R9 reset boot_direct", boot_direct, 1'b0);
    chk("R9 reset fmt_locked", fmt_locked, 1'b0);

    for (int combo = 0; combo < 16; combo++) begin
      @(negedge clk);
      rst_n = 1'b0;
      s_off = combo[0]; s_auto = combo[1]; s_boot = combo[2]; s_fmt = combo[3];
      exp_mapped = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      // R11: right after reset release, synced switches still read 0
      @(posedge clk); #2;
      chk("R11 early boot_direct", boot_direct, 1'b0);
      @(posedge clk); #2;
      chk("R11 boot_direct at depth", boot_direct, s_boot);
      chk("R9 fmt_locked", fmt_locked, s_fmt);
      settle();
      fmt_req = 1'b1; #1 chk("R10 grant req1", fmt_grant, !s_fmt);
      fmt_req = 1'b0; #1 chk("R10 grant req0", fmt_grant, 1'b0);
      // R7 / R1 / R2
      sweep(s_off ? "R2" : "R7 R1");
      // R6
      for (int k = 0; k < 4; k++) begin
        logic [7:0] p;
        p = 8'($urandom);
        if (p == 8'h40) p = 8'h41;
        io_write(p);
      end
      rd_probe("R6 other ports", 16'hC000, 1'b1, 1'b0);
      io_write(8'h40);
      sweep(s_auto ? "R4" : "R5");
      // R8: drop auto-off switch, flag must not return
      s_auto = 1'b0;
      settle();
      rd_probe("R8 stays", 16'hC200, 1'b1, 1'b0);
      s_auto = combo[1];
      // random traffic
      for (int n = 0; n < 60; n++) begin
        logic [15:0] a;
        a = ($urandom % 2) ? 16'hBF00 + 16'($urandom % 16'h0600) : 16'($urandom);
        rd_probe("R1 random", a, 1'($urandom), 1'($urandom % 4 == 0));
      end
    end

    // R11: ROM-off switch takes effect two edges after it changes
    @(negedge clk); rst_n = 1'b0; s_off = 1'b0; s_auto = 1'b0; exp_mapped = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    settle();
    mem_addr = 16'hC100; mem_rd = 1'b1; mem_wr = 1'b0;
    s_off = 1'b1;
    @(posedge clk); #2 chk("R11 off after 1 edge", rom_ce, 1'b1);
    @(posedge clk); #2 chk("R11 off after 2 edges", rom_ce, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule